// File: doc/BRIEF.md
# Register-Controlled MDIO Management Master

This block drives the two-wire station-management bus of an Ethernet PHY. Software programs a target PHY address, a register number and a direction into an address register, loads a 16-bit value into a write-data register when writing, and then sets a self-clearing status bit in a control register. The block then produces the management clock and shifts out one complete clause-22 frame. On a read it releases the data line, samples the PHY's reply, and stores the 16 bits in a read-data register. A separate enable bit gates whether a start request is accepted at all.

The management clock is derived from the system clock. It stays high for `MDC_HALF` system cycles and low for `MDC_HALF` cycles for every frame bit, and it idles low between frames. The data line changes only while the management clock is low, so the PHY always samples a settled bit on the rising edge. Register reads on the host side are combinational from the offset.

Top module: `mdio_master_regs`

## Requirements
- R1: The address register lives at byte offset 0x7E4. Bits 4:0 hold the register number, bits 9:5 the PHY address and bit 10 the direction (1 = read, 0 = write). Bits 10:0 read back as written and the upper bits read 0.
- R2: The control register lives at offset 0x7F0. Bit 3 is the enable flag, which is written and read back. Bit 0 reads 1 while a frame is in progress and 0 otherwise. All other bits read 0.
- R3: A write to the control register with both bit 0 and bit 3 set, while idle, starts a frame. Status reads 1 from the next cycle and returns to 0 exactly 128*MDC_HALF cycles after the start write.
- R4: A control write with bit 3 clear starts nothing. Status stays 0 and the management clock does not toggle.
- R5: Each frame is 64 bits, most significant bit first: 32 ones, start 01, opcode (10 read, 01 write), the 5-bit PHY address, the 5-bit register number, a 2-bit turnaround, then 16 data bits. A write frame drives turnaround 10 and data from bits 15:0 of the write-data register (offset 0x7E8). The master drives the line for every bit up to the end of the register number.
- R6: In a read frame the master releases the line (output enable low) from the first turnaround bit through the last data bit. It samples the line on each management-clock rising edge of the data phase and loads the result into bits 15:0 of the read-data register (offset 0x7EC) when the frame ends.
- R7: A write frame leaves the read-data register unchanged.
- R8: The management clock is low when idle and toggles every MDC_HALF system cycles during a frame. The data line and its enable never change while the management clock is high.
- R9: While a frame runs, a new start request is ignored, including one that arrives in the frame's final cycle. It is not queued, so status reads 0 after completion. Rewriting the address or write-data register mid-frame does not alter the bits being sent.
- R10: After reset all registers read 0, the management clock is low and the line is released.
- R11: Writes to the read-data offset or to any unmapped offset have no effect on the readable registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register byte offset |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data, combinational from reg_addr_i |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The risky overlap is a control-register write and frame completion in the same cycle. If the two were mishandled, the start request would either be lost without notice or begin an unintended back-to-back frame. The bench counts cycles from the accepted start write and checks that status still reads 1 one cycle before the frame's computed length. In that last cycle it issues a second start write, then checks that status reads 0 afterwards and that the management clock stays quiet. A mid-frame rewrite of the address register is judged in the same way: the captured frame bits are compared with the values that were programmed before the start.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned FRAME_BITS = 64;
  localparam int unsigned IDX_W      = $clog2(FRAME_BITS);
  localparam int unsigned TA_IDX     = 46;
  localparam int unsigned DATA_IDX   = 48;
  localparam int unsigned MD_W       = 16;

  localparam int unsigned OFS_ADDR = 32'h7E4;
  localparam int unsigned OFS_WDAT = 32'h7E8;
  localparam int unsigned OFS_RDAT = 32'h7EC;
  localparam int unsigned OFS_CTRL = 32'h7F0;

  localparam int unsigned CTRL_GO_BIT = 0;
  localparam int unsigned CTRL_EN_BIT = 3;

  typedef struct packed {
    logic       rd;
    logic [4:0] phy;
    logic [4:0] regn;
  } mgmt_addr_t;

  function automatic logic [FRAME_BITS-1:0] build_frame(mgmt_addr_t a, logic [MD_W-1:0] wd);
    logic [1:0] op, ta;
    logic [MD_W-1:0] dat;
    op  = a.rd ? 2'b10 : 2'b01;
    ta  = a.rd ? 2'b11 : 2'b10;
    dat = a.rd ? '1 : wd;
    return {32'hFFFF_FFFF, 2'b01, op, a.phy, a.regn, ta, dat};
  endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int unsigned MDC_HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  logic mdc_q;
  logic last;

  generate
    if (MDC_HALF <= 1) begin : g_nodiv
      assign last = 1'b1;
    end else begin : g_div
      localparam int unsigned CW = $clog2(MDC_HALF);
      logic [CW-1:0] cnt_q;
      assign last = (cnt_q == CW'(MDC_HALF - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)             cnt_q <= '0;
        else if (!run_i || last) cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mdc_q <= 1'b0;
    else if (!run_i) mdc_q <= 1'b0;
    else if (last)   mdc_q <= ~mdc_q;
  end

  assign mdc_o  = mdc_q;
  assign rise_o = run_i & ~mdc_q & last;
  assign fall_o = run_i &  mdc_q & last;
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  mgmt_addr_t       addr_i,
  input  logic [MD_W-1:0]  wdata_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             mdio_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             rd_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [MD_W-1:0]  rcap_o,
  output logic             mdio_o,
  output logic             mdio_oe_o
);
  logic [FRAME_BITS-1:0] sh_q;
  logic [IDX_W-1:0]      idx_q;
  logic                  busy_q, rd_q;
  logic [MD_W-1:0]       rcap_q;
  logic                  at_last;

  assign at_last = (idx_q == IDX_W'(FRAME_BITS - 1));
  assign done_o  = busy_q & fall_i & at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      idx_q  <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
    end else if (start_i && !busy_q) begin
      sh_q   <= build_frame(addr_i, wdata_i);
      idx_q  <= '0;
      busy_q <= 1'b1;
      rd_q   <= addr_i.rd;
    end else if (busy_q && fall_i) begin
      if (at_last) begin
        busy_q <= 1'b0;
      end else begin
        sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b1};
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  // read data shifts in on MDC rising edges of the data phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      rcap_q <= '0;
    else if (busy_q && rd_q && rise_i && idx_q >= IDX_W'(DATA_IDX))
      rcap_q <= {rcap_q[MD_W-2:0], mdio_i};
  end

  assign busy_o    = busy_q;
  assign rd_o      = rd_q;
  assign idx_o     = idx_q;
  assign rcap_o    = rcap_q;
  assign mdio_o    = sh_q[FRAME_BITS-1];
  assign mdio_oe_o = busy_q & ~(rd_q & (idx_q >= IDX_W'(TA_IDX)));
endmodule

// File: rtl/mdio_csr.sv
module mdio_csr
  import mdio_pkg::*;
#(
  parameter int unsigned AW = 13,
  parameter int unsigned DW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic            busy_i,
  input  logic            done_i,
  input  logic            frame_rd_i,
  input  logic [MD_W-1:0] rcap_i,
  output mgmt_addr_t      maddr_o,
  output logic [MD_W-1:0] mwdata_o,
  output logic            ctrl_wr_o,
  output logic            start_o
);
  mgmt_addr_t      maddr_q;
  logic [MD_W-1:0] wd_q, rd_q;
  logic            en_q;
  logic sel_addr, sel_wdat, sel_rdat, sel_ctrl;
  logic wdata_unused;

  assign sel_addr = (addr_i == AW'(OFS_ADDR));
  assign sel_wdat = (addr_i == AW'(OFS_WDAT));
  assign sel_rdat = (addr_i == AW'(OFS_RDAT));
  assign sel_ctrl = (addr_i == AW'(OFS_CTRL));

  assign ctrl_wr_o = wr_i & sel_ctrl;
  assign start_o   = ctrl_wr_o & wdata_i[CTRL_GO_BIT] & wdata_i[CTRL_EN_BIT] & ~busy_i;
  assign wdata_unused = ^wdata_i[DW-1:MD_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      maddr_q <= '0;
      wd_q    <= '0;
      rd_q    <= '0;
      en_q    <= 1'b0;
    end else begin
      if (wr_i && sel_addr) maddr_q <= wdata_i[$bits(mgmt_addr_t)-1:0];
      if (wr_i && sel_wdat) wd_q    <= wdata_i[MD_W-1:0];
      if (ctrl_wr_o)        en_q    <= wdata_i[CTRL_EN_BIT];
      if (done_i && frame_rd_i) rd_q <= rcap_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_addr) rdata_o = DW'(maddr_q);
    if (sel_wdat) rdata_o = DW'(wd_q);
    if (sel_rdat) rdata_o = DW'(rd_q);
    if (sel_ctrl) begin
      rdata_o[CTRL_EN_BIT] = en_q;
      rdata_o[CTRL_GO_BIT] = busy_i;
    end
  end

  assign maddr_o  = maddr_q;
  assign mwdata_o = wd_q;
endmodule

// File: rtl/mdio_master_regs.sv
module mdio_master_regs
  import mdio_pkg::*;
#(
  parameter int unsigned AW       = 13,
  parameter int unsigned DW       = 32,
  parameter int unsigned MDC_HALF = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          mdc_o,
  output logic          mdio_o,
  output logic          mdio_oe_o,
  input  logic          mdio_i
);
  mgmt_addr_t       maddr;
  logic [MD_W-1:0]  mwdata, rcap;
  logic             start, busy, frame_done, cur_rd, ctrl_wr;
  logic             rise, fall;
  logic [IDX_W-1:0] bit_idx;

  mdio_csr #(.AW(AW), .DW(DW)) u_csr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .busy_i     (busy),
    .done_i     (frame_done),
    .frame_rd_i (cur_rd),
    .rcap_i     (rcap),
    .maddr_o    (maddr),
    .mwdata_o   (mwdata),
    .ctrl_wr_o  (ctrl_wr),
    .start_o    (start)
  );

  mdio_clkdiv #(.MDC_HALF(MDC_HALF)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .addr_i    (maddr),
    .wdata_i   (mwdata),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .busy_o    (busy),
    .done_o    (frame_done),
    .rd_o      (cur_rd),
    .idx_o     (bit_idx),
    .rcap_o    (rcap),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o)
  );
endmodule

// File: rtl/mdio_master_regs_chk.sv
module mdio_master_regs_chk
  import mdio_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mdc_o,
  input logic             mdio_o,
  input logic             mdio_oe_o,
  input logic             busy,
  input logic             frame_done,
  input logic             cur_rd,
  input logic             ctrl_wr,
  input logic             en_bit,
  input logic [IDX_W-1:0] bit_idx
);
  a_r8_mdc_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mdc_o);

  a_r8_mdio_hold_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdc_o |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

  a_r6_release_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && cur_rd && bit_idx >= IDX_W'(TA_IDX)) |-> !mdio_oe_o);

  a_r5_drive_hdr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && bit_idx < IDX_W'(TA_IDX)) |-> mdio_oe_o);

  a_r10_idle_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mdio_oe_o);

  a_r4_no_start_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && !en_bit && !busy) |=> !busy);

  a_r9_no_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !frame_done) |=> busy);

  a_r9_done_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done |=> !busy);
endmodule

bind mdio_master_regs mdio_master_regs_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mdc_o      (mdc_o),
  .mdio_o     (mdio_o),
  .mdio_oe_o  (mdio_oe_o),
  .busy       (busy),
  .frame_done (frame_done),
  .cur_rd     (cur_rd),
  .ctrl_wr    (ctrl_wr),
  .en_bit     (reg_wdata_i[3]),
  .bit_idx    (bit_idx)
);

// File: tb/mdio_master_regs_tb.sv
`timescale 1ns/1ps
module mdio_master_regs_tb;
  localparam int AW = 13, DW = 32, HALF = 2;
  localparam int FLEN = 128 * HALF;
  localparam logic [AW-1:0] A_ADDR = 13'h7E4, A_WDAT = 13'h7E8,
                            A_RDAT = 13'h7EC, A_CTRL = 13'h7F0;
  localparam int NV = 6;
  // {rd, phy, regn, wdata, phy_reply}
  localparam logic [42:0] VEC [NV] = '{
    {1'b1, 5'd1,  5'd1,  16'h0000, 16'h796D},
    {1'b0, 5'd31, 5'd0,  16'hA5C3, 16'h0000},
    {1'b1, 5'd0,  5'd31, 16'h0000, 16'h8001},
    {1'b0, 5'd10, 5'd21, 16'hFFFF, 16'h0000},
    {1'b1, 5'd21, 5'd10, 16'h1234, 16'hFFFF},
    {1'b0, 5'd5,  5'd18, 16'h0000, 16'h0000}
  };

  logic clk = 0, rst_n = 0;
  logic wr = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic mdc, mdio_o, mdio_oe, mdio_i;

  int tests = 0, fails = 0;
  bit finished = 0;

  logic [63:0] cap_o = '1, cap_oe = '0;
  int idx = 0, rises = 0;
  logic [15:0] phy_data = '0;

  always #2.5 clk = ~clk;

  mdio_master_regs #(.AW(AW), .DW(DW), .MDC_HALF(HALF)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mdc_o(mdc),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe), .mdio_i(mdio_i));

  // PHY model: replies in the data phase of every frame
  assign mdio_i = (idx >= 48) ? phy_data[63 - idx] : 1'b1;

  always @(posedge mdc) begin
    cap_o[63 - idx]  = mdio_o;
    cap_oe[63 - idx] = mdio_oe;
    idx   = (idx == 63) ? 0 : idx + 1;
    rises = rises + 1;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk64(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    wr = 1; addr = a; wdata = d;
    @(negedge clk);
    wr = 0; wdata = '0;
  endtask

  task automatic bus_read(logic [AW-1:0] a, output logic [DW-1:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_idle();
    logic [DW-1:0] s;
    for (int k = 0; k < 4 * FLEN; k++) begin
      @(negedge clk);
      bus_read(A_CTRL, s);
      if (s[0] == 1'b0) return;
    end
  endtask

  function automatic logic [63:0] exp_frame(logic rd, logic [4:0] p, logic [4:0] r,
                                            logic [15:0] d);
    if (rd) return {32'hFFFF_FFFF, 2'b01, 2'b10, p, r, 18'h0};
    return {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d};
  endfunction

  function automatic logic [63:0] exp_oe(logic rd);
    return rd ? {{46{1'b1}}, 18'h0} : '1;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] r, prev;
    logic [42:0] v;
    int r0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R10 reset state
    bus_read(A_ADDR, r); chk("R10 addr reset", r, 0);
    bus_read(A_WDAT, r); chk("R10 wdata reset", r, 0);
    bus_read(A_RDAT, r); chk("R10 rdata reset", r, 0);
    bus_read(A_CTRL, r); chk("R10 ctrl reset", r, 0);
    chk("R10 mdc low", {31'd0, mdc}, 0);
    chk("R10 released", {31'd0, mdio_oe}, 0);

    // R1 field readback
    bus_write(A_ADDR, 32'hFFFF_F000 | 32'h5A5);
    bus_read(A_ADDR, r); chk("R1 addr readback", r, 32'h5A5);
    // R2 enable without go
    bus_write(A_CTRL, 32'h8);
    bus_read(A_CTRL, r); chk("R2 enable readback", r, 32'h8);

    // R4 go without enable
    r0 = rises;
    bus_write(A_CTRL, 32'h1);
    repeat (4 * HALF + 4) @(negedge clk);
    bus_read(A_CTRL, r); chk("R4 no start when disabled", r, 0);
    chk("R4 mdc quiet", rises - r0, 0);

    // R11 writes to read-only/unmapped offsets
    bus_write(A_RDAT, 32'hDEAD_BEEF);
    bus_write(13'h000, 32'hFFFF_FFFF);
    bus_read(A_RDAT, r); chk("R11 rdata not writable", r, 0);
    bus_read(13'h000, r); chk("R11 unmapped reads 0", r, 0);
    bus_read(A_ADDR, r); chk("R11 addr untouched", r, 32'h5A5);

    // table-driven frames
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      phy_data = v[15:0];
      bus_write(A_ADDR, {21'd0, v[42], v[41:37], v[36:32]});
      bus_write(A_WDAT, {16'hBEEF, v[31:16]});
      bus_read(A_RDAT, prev);
      bus_write(A_CTRL, 32'h9);
      bus_read(A_CTRL, r); chk("R3 status set after start", r, 32'h9);
      wait_idle();
      chk64("R5 frame bits", cap_o & exp_oe(v[42]),
            exp_frame(v[42], v[41:37], v[36:32], v[31:16]) & exp_oe(v[42]));
      chk64(v[42] ? "R6 release pattern" : "R5 drive pattern", cap_oe, exp_oe(v[42]));
      bus_read(A_RDAT, r);
      if (v[42]) chk("R6 read data captured", r, {16'd0, v[15:0]});
      else       chk("R7 rdata unchanged by write", r, prev);
    end

    // R3/R9 exact length and start collision in the final cycle
    phy_data = 16'h0F0F;
    bus_write(A_ADDR, 32'h400 | (5'd3 << 5) | 5'd2);
    bus_write(A_CTRL, 32'h9);
    repeat (FLEN - 1) @(negedge clk);
    bus_read(A_CTRL, r); chk("R3 status held until last cycle", r, 32'h9);
    wr = 1; addr = A_CTRL; wdata = 32'h9;
    @(negedge clk);
    wr = 0; wdata = '0;
    bus_read(A_CTRL, r); chk("R3 status clears at frame end", r, 32'h8);
    r0 = rises;
    repeat (4 * HALF + 4) @(negedge clk);
    bus_read(A_CTRL, r); chk("R9 late start not queued", r, 32'h8);
    chk("R9 mdc quiet after collision", rises - r0, 0);
    bus_read(A_RDAT, r); chk("R6 read data after collision", r, 32'h0F0F);

    // R9 register rewrite mid-frame, R8 mdc period
    phy_data = 16'h0;
    bus_write(A_ADDR, (5'd9 << 5) | 5'd17);
    bus_write(A_WDAT, 32'h3C3C);
    bus_write(A_CTRL, 32'h9);
    repeat (10) @(negedge clk);
    bus_write(A_ADDR, 32'h7FF);
    bus_write(A_WDAT, 32'hFFFF);
    r0 = rises;
    repeat (20 * HALF) @(negedge clk);
    chk("R8 mdc rises per 2*HALF cycles", rises - r0, 10);
    wait_idle();
    chk64("R9 frame unaffected by rewrite", cap_o,
          exp_frame(1'b0, 5'd9, 5'd17, 16'h3C3C));
    bus_read(A_ADDR, r); chk("R9 addr reg took new value", r, 32'h7FF);
    chk("R8 mdc idle low", {31'd0, mdc}, 0);

    finish_run();
  end
endmodule